// File: doc/BRIEF.md
# Audio Sample FIFO Pair with Threshold Events

This block sits between a register port and the serial audio engine. It holds two word queues: an outbound one, which software fills through a data register and the serializer drains, and an inbound one, which the deserializer fills and software empties. Each queue reports how many words it holds. Each raises a status bit when its fill crosses a programmable threshold, and each can ask a DMA engine for service when its fill reaches a programmable level.

Software drives a simple register port. A read returns its data one clock after the read strobe. Writing to the data register pushes a word into the outbound queue, and reading the other data register pops a word from the inbound queue. Thresholds are programmed as the wanted value minus one. The flush bits stay at 1 while a flush is in progress, so software polls them until they fall.

The serializer side is valid/ready. `tx_valid` depends only on state, and a word leaves on a cycle with both `tx_valid` and `tx_ready` high. While `tx_valid` is high and `tx_ready` is low, `tx_data` holds its value. The deserializer side works the same way in the other direction. `rx_ready` depends only on state and is low while the inbound queue is full or flushing, and a word is taken on a cycle with both `rx_valid` and `rx_ready` high.

Top module: `aud_fifo_ctl`

## Requirements
- R1: Each queue holds up to DEPTH words and delivers them in the order they arrived. Its fill count reads back in the low bits of the level registers: address 6 for outbound, address 7 for inbound.
- R2: A write to the outbound data register (address 4) while that queue holds DEPTH words is dropped. The inbound queue never exceeds DEPTH words.
- R3: A read of the inbound data register (address 5) while that queue is empty or flushing returns 0 and leaves the level unchanged.
- R4: `tx_valid` is high exactly when the outbound queue is non-empty and not flushing. `tx_data` shows the oldest word, and it stays stable while `tx_valid` is high and `tx_ready` is low.
- R5: `rx_ready` is high exactly when the inbound queue holds fewer than DEPTH words and is not flushing. A word is stored on a cycle with `rx_valid` and `rx_ready` both high.
- R6: Status bit 0 (status register, address 1) is 1 while the outbound level is at or below T+1. T is the field at bits 4 and up of the interrupt control register (address 0).
- R7: Status bit 16 is 1 while the inbound level is at or above R+1. R is the field at bits 20 and up of the interrupt control register.
- R8: Status bit 1 (underrun) becomes 1 after any cycle with `tx_ready` high and `tx_valid` low. It stays 1 until a write to address 0 with bit 2 set. A new underrun in that same cycle wins, and bit 2 always reads back 0.
- R9: `irq` is the OR of status bit 0 masked by enable bit 0 and status bit 16 masked by enable bit 16, both enables sitting in the interrupt control register.
- R10: `tx_dma_req` is high when DMA control (address 2) bit 8 is set and the outbound level is at or below the field at bits 0 and up. `rx_dma_req` is high when bit 24 is set and the inbound level is above the field at bits 16 and up.
- R11: Writing 1 to bit 0 (outbound) or bit 1 (inbound) of the flush register (address 3) makes that bit read 1 for exactly FLUSH_CYCLES cycles. During that time the queue is frozen. When the bit clears, the queue is empty.
- R12: A read strobe latches the addressed register into `reg_rdata` at the next clock edge. `reg_rdata` holds its value on cycles with no read. Address 4 reads 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| reg_wr | input | 1 | Register write strobe |
| reg_rd | input | 1 | Register read strobe |
| reg_addr | input | 3 | Register word address |
| reg_wdata | input | 32 | Write data |
| reg_rdata | output | 32 | Read data, valid the cycle after the strobe |
| tx_valid | output | 1 | Outbound word available |
| tx_ready | input | 1 | Serializer takes a word |
| tx_data | output | 32 | Oldest outbound word |
| rx_valid | input | 1 | Deserializer offers a word |
| rx_ready | output | 1 | Inbound queue accepts a word |
| rx_data | input | 32 | Inbound word |
| irq | output | 1 | Combined enabled threshold event |
| tx_dma_req | output | 1 | Outbound DMA service request |
| rx_dma_req | output | 1 | Inbound DMA service request |

## Verification
The bench builds the block with DEPTH set to 8 and FLUSH_CYCLES set to 3. With that depth, full and overflow conditions on both queues take only a handful of cycles, and the three-bit threshold and DMA fields can be swept across their whole range. A three-cycle flush leaves room to read the flush bit and the frozen level while a flush is still in progress. A pseudo-random phase then mixes register traffic, stream back-pressure, flushes and reprogramming against the behavioural model.

// File: rtl/aud_fifo_pkg.sv
package aud_fifo_pkg;
  localparam int REG_W  = 32;
  localparam int ADDR_W = 3;

  typedef enum logic [ADDR_W-1:0] {
    A_IRQ_CTL  = 3'd0,
    A_IRQ_STAT = 3'd1,
    A_DMA_CTL  = 3'd2,
    A_FLUSH    = 3'd3,
    A_TX_DATA  = 3'd4,
    A_RX_DATA  = 3'd5,
    A_TX_LVL   = 3'd6,
    A_RX_LVL   = 3'd7
  } reg_addr_e;

  // bit positions that software decodes
  localparam int TXE_BIT     = 0;
  localparam int UND_BIT     = 1;
  localparam int UND_CLR_BIT = 2;
  localparam int TX_THR_LSB  = 4;
  localparam int RXF_BIT     = 16;
  localparam int RX_THR_LSB  = 20;
  localparam int TX_DMA_LSB  = 0;
  localparam int TX_DMA_EN   = 8;
  localparam int RX_DMA_LSB  = 16;
  localparam int RX_DMA_EN   = 24;
  localparam int FL_TX_BIT   = 0;
  localparam int FL_RX_BIT   = 1;

  typedef struct packed {
    logic rxf;
    logic und;
    logic txe;
  } irq_stat_t;
endpackage

// File: rtl/aud_sync_fifo.sv
module aud_sync_fifo #(
  parameter int DEPTH        = 32,
  parameter int DATA_W       = 32,
  parameter int FLUSH_CYCLES = 4,
  localparam int AW          = $clog2(DEPTH),
  localparam int LVL_W       = AW + 1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              push,
  input  logic [DATA_W-1:0] push_data,
  input  logic              pop,
  output logic [DATA_W-1:0] head,
  input  logic              flush_req,
  output logic              busy,
  output logic [LVL_W-1:0]  level,
  output logic              full,
  output logic              empty
);
  localparam int CNT_W = $clog2(FLUSH_CYCLES + 1);

  logic [DATA_W-1:0] mem [DEPTH];
  logic [LVL_W-1:0]  wr_ptr, rd_ptr;
  logic [CNT_W-1:0]  cnt;
  logic              push_ok, pop_ok;

  assign level   = wr_ptr - rd_ptr;
  assign full    = (level == LVL_W'(DEPTH));
  assign empty   = (level == '0);
  assign push_ok = push && !full && !busy;
  assign pop_ok  = pop && !empty && !busy;
  assign head    = mem[rd_ptr[AW-1:0]];

  always_ff @(posedge clk) begin
    if (push_ok) mem[wr_ptr[AW-1:0]] <= push_data;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wr_ptr <= '0;
      rd_ptr <= '0;
      busy   <= 1'b0;
      cnt    <= '0;
    end else if (busy) begin
      if (cnt == '0) begin
        busy   <= 1'b0;
        wr_ptr <= '0;
        rd_ptr <= '0;
      end else begin
        cnt <= cnt - 1'b1;
      end
    end else begin
      if (push_ok) wr_ptr <= wr_ptr + 1'b1;
      if (pop_ok)  rd_ptr <= rd_ptr + 1'b1;
      if (flush_req) begin
        busy <= 1'b1;
        cnt  <= CNT_W'(FLUSH_CYCLES - 1);
      end
    end
  end

  assert_no_overflow_R2: assert property (@(posedge clk) disable iff (!rst_n)
    level <= LVL_W'(DEPTH));

  assert_level_step_R1: assert property (@(posedge clk) disable iff (!rst_n)
    !$past(busy) |-> (level == $past(level)) || (level == $past(level) + 1'b1)
                     || (level == $past(level) - 1'b1));

  assert_flush_empties_R11: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(busy) |-> empty);
endmodule

// File: rtl/aud_fifo_regs.sv
module aud_fifo_regs
  import aud_fifo_pkg::*;
#(
  parameter int LVL_W = 6,
  parameter int FLD_W = 5
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              reg_wr,
  input  logic              reg_rd,
  input  logic [ADDR_W-1:0] reg_addr,
  input  logic [REG_W-1:0]  reg_wdata,
  output logic [REG_W-1:0]  reg_rdata,
  input  logic [LVL_W-1:0]  tx_level,
  input  logic [LVL_W-1:0]  rx_level,
  input  logic [REG_W-1:0]  rx_head,
  input  logic              rx_empty,
  input  logic              tx_busy,
  input  logic              rx_busy,
  input  irq_stat_t         stat,
  output logic              tx_push,
  output logic              rx_pop,
  output logic              tx_flush,
  output logic              rx_flush,
  output logic              und_clr,
  output logic              txe_en,
  output logic              rxf_en,
  output logic [FLD_W-1:0]  tx_thr,
  output logic [FLD_W-1:0]  rx_thr,
  output logic              tx_dma_en,
  output logic              rx_dma_en,
  output logic [FLD_W-1:0]  tx_dma_lvl,
  output logic [FLD_W-1:0]  rx_dma_lvl
);
  reg_addr_e  addr;
  logic [REG_W-1:0] rd_val;

  assign addr     = reg_addr_e'(reg_addr);
  assign tx_push  = reg_wr && (addr == A_TX_DATA);
  assign rx_pop   = reg_rd && (addr == A_RX_DATA);
  assign tx_flush = reg_wr && (addr == A_FLUSH) && reg_wdata[FL_TX_BIT];
  assign rx_flush = reg_wr && (addr == A_FLUSH) && reg_wdata[FL_RX_BIT];
  assign und_clr  = reg_wr && (addr == A_IRQ_CTL) && reg_wdata[UND_CLR_BIT];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      txe_en     <= 1'b0;
      rxf_en     <= 1'b0;
      tx_thr     <= '0;
      rx_thr     <= '0;
      tx_dma_en  <= 1'b0;
      rx_dma_en  <= 1'b0;
      tx_dma_lvl <= '0;
      rx_dma_lvl <= '0;
    end else if (reg_wr) begin
      if (addr == A_IRQ_CTL) begin
        txe_en <= reg_wdata[TXE_BIT];
        rxf_en <= reg_wdata[RXF_BIT];
        tx_thr <= reg_wdata[TX_THR_LSB +: FLD_W];
        rx_thr <= reg_wdata[RX_THR_LSB +: FLD_W];
      end
      if (addr == A_DMA_CTL) begin
        tx_dma_en  <= reg_wdata[TX_DMA_EN];
        rx_dma_en  <= reg_wdata[RX_DMA_EN];
        tx_dma_lvl <= reg_wdata[TX_DMA_LSB +: FLD_W];
        rx_dma_lvl <= reg_wdata[RX_DMA_LSB +: FLD_W];
      end
    end
  end

  always_comb begin
    rd_val = '0;
    case (addr)
      A_IRQ_CTL: begin
        rd_val[TXE_BIT]               = txe_en;
        rd_val[RXF_BIT]               = rxf_en;
        rd_val[TX_THR_LSB +: FLD_W]   = tx_thr;
        rd_val[RX_THR_LSB +: FLD_W]   = rx_thr;
      end
      A_IRQ_STAT: begin
        rd_val[TXE_BIT] = stat.txe;
        rd_val[UND_BIT] = stat.und;
        rd_val[RXF_BIT] = stat.rxf;
      end
      A_DMA_CTL: begin
        rd_val[TX_DMA_EN]             = tx_dma_en;
        rd_val[RX_DMA_EN]             = rx_dma_en;
        rd_val[TX_DMA_LSB +: FLD_W]   = tx_dma_lvl;
        rd_val[RX_DMA_LSB +: FLD_W]   = rx_dma_lvl;
      end
      A_FLUSH: begin
        rd_val[FL_TX_BIT] = tx_busy;
        rd_val[FL_RX_BIT] = rx_busy;
      end
      A_RX_DATA: rd_val = (rx_empty || rx_busy) ? '0 : rx_head;
      A_TX_LVL:  rd_val[LVL_W-1:0] = tx_level;
      A_RX_LVL:  rd_val[LVL_W-1:0] = rx_level;
      default:   rd_val = '0;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      reg_rdata <= '0;
    else if (reg_rd) reg_rdata <= rd_val;
  end

  assert_rdata_hold_R12: assert property (@(posedge clk) disable iff (!rst_n)
    !$past(reg_rd) |-> $stable(reg_rdata));
endmodule

// File: rtl/aud_fifo_events.sv
module aud_fifo_events
  import aud_fifo_pkg::*;
#(
  parameter int LVL_W = 6,
  parameter int FLD_W = 5
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [LVL_W-1:0] tx_level,
  input  logic [LVL_W-1:0] rx_level,
  input  logic [FLD_W-1:0] tx_thr,
  input  logic [FLD_W-1:0] rx_thr,
  input  logic             txe_en,
  input  logic             rxf_en,
  input  logic             tx_dma_en,
  input  logic             rx_dma_en,
  input  logic [FLD_W-1:0] tx_dma_lvl,
  input  logic [FLD_W-1:0] rx_dma_lvl,
  input  logic             tx_valid,
  input  logic             tx_ready,
  input  logic             und_clr,
  output irq_stat_t        stat,
  output logic             irq,
  output logic             tx_dma_req,
  output logic             rx_dma_req
);
  logic [LVL_W-1:0] tx_lim, rx_lim;
  logic             und_q;

  // fields hold threshold minus one
  assign tx_lim   = LVL_W'(tx_thr) + LVL_W'(1);
  assign rx_lim   = LVL_W'(rx_thr) + LVL_W'(1);
  assign stat.txe = (tx_level <= tx_lim);
  assign stat.rxf = (rx_level >= rx_lim);
  assign stat.und = und_q;

  assign irq        = (stat.txe && txe_en) || (stat.rxf && rxf_en);
  assign tx_dma_req = tx_dma_en && (tx_level <= LVL_W'(tx_dma_lvl));
  assign rx_dma_req = rx_dma_en && (rx_level >  LVL_W'(rx_dma_lvl));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                    und_q <= 1'b0;
    else if (tx_ready && !tx_valid) und_q <= 1'b1;
    else if (und_clr)              und_q <= 1'b0;
  end

  assert_und_cause_R8: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(und_q) |-> $past(tx_ready && !tx_valid));

  assert_und_sticky_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (und_q && !und_clr) |=> und_q);
endmodule

// File: rtl/aud_fifo_ctl.sv
module aud_fifo_ctl
  import aud_fifo_pkg::*;
#(
  parameter int DEPTH        = 32,
  parameter int FLUSH_CYCLES = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              reg_wr,
  input  logic              reg_rd,
  input  logic [2:0]        reg_addr,
  input  logic [31:0]       reg_wdata,
  output logic [31:0]       reg_rdata,
  output logic              tx_valid,
  input  logic              tx_ready,
  output logic [31:0]       tx_data,
  input  logic              rx_valid,
  output logic              rx_ready,
  input  logic [31:0]       rx_data,
  output logic              irq,
  output logic              tx_dma_req,
  output logic              rx_dma_req
);
  localparam int AW    = $clog2(DEPTH);
  localparam int LVL_W = AW + 1;
  localparam int FLD_W = AW;

  logic [LVL_W-1:0] tx_level, rx_level;
  logic [REG_W-1:0] rx_head;
  logic tx_busy, rx_busy, tx_full, tx_empty, rx_full, rx_empty;
  logic tx_push, rx_pop, tx_flush, rx_flush, und_clr;
  logic txe_en, rxf_en, tx_dma_en, rx_dma_en;
  logic [FLD_W-1:0] tx_thr, rx_thr, tx_dma_lvl, rx_dma_lvl;
  irq_stat_t stat;

  assign tx_valid = !tx_empty && !tx_busy;
  assign rx_ready = !rx_full && !rx_busy;

  aud_sync_fifo #(.DEPTH(DEPTH), .DATA_W(REG_W), .FLUSH_CYCLES(FLUSH_CYCLES)) u_tx_q (
    .clk(clk), .rst_n(rst_n),
    .push(tx_push), .push_data(reg_wdata),
    .pop(tx_valid && tx_ready), .head(tx_data),
    .flush_req(tx_flush), .busy(tx_busy),
    .level(tx_level), .full(tx_full), .empty(tx_empty)
  );

  aud_sync_fifo #(.DEPTH(DEPTH), .DATA_W(REG_W), .FLUSH_CYCLES(FLUSH_CYCLES)) u_rx_q (
    .clk(clk), .rst_n(rst_n),
    .push(rx_valid && rx_ready), .push_data(rx_data),
    .pop(rx_pop), .head(rx_head),
    .flush_req(rx_flush), .busy(rx_busy),
    .level(rx_level), .full(rx_full), .empty(rx_empty)
  );

  aud_fifo_regs #(.LVL_W(LVL_W), .FLD_W(FLD_W)) u_regs (
    .clk(clk), .rst_n(rst_n),
    .reg_wr(reg_wr), .reg_rd(reg_rd), .reg_addr(reg_addr),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
    .tx_level(tx_level), .rx_level(rx_level), .rx_head(rx_head),
    .rx_empty(rx_empty), .tx_busy(tx_busy), .rx_busy(rx_busy), .stat(stat),
    .tx_push(tx_push), .rx_pop(rx_pop), .tx_flush(tx_flush), .rx_flush(rx_flush),
    .und_clr(und_clr), .txe_en(txe_en), .rxf_en(rxf_en),
    .tx_thr(tx_thr), .rx_thr(rx_thr),
    .tx_dma_en(tx_dma_en), .rx_dma_en(rx_dma_en),
    .tx_dma_lvl(tx_dma_lvl), .rx_dma_lvl(rx_dma_lvl)
  );

  aud_fifo_events #(.LVL_W(LVL_W), .FLD_W(FLD_W)) u_events (
    .clk(clk), .rst_n(rst_n),
    .tx_level(tx_level), .rx_level(rx_level),
    .tx_thr(tx_thr), .rx_thr(rx_thr),
    .txe_en(txe_en), .rxf_en(rxf_en),
    .tx_dma_en(tx_dma_en), .rx_dma_en(rx_dma_en),
    .tx_dma_lvl(tx_dma_lvl), .rx_dma_lvl(rx_dma_lvl),
    .tx_valid(tx_valid), .tx_ready(tx_ready), .und_clr(und_clr),
    .stat(stat), .irq(irq), .tx_dma_req(tx_dma_req), .rx_dma_req(rx_dma_req)
  );

  assert_tx_hold_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (tx_valid && !tx_ready) |=> $stable(tx_data));

  assert_full_no_txdma_R10: assert property (@(posedge clk) disable iff (!rst_n)
    tx_full |-> !tx_dma_req);

  assert_rx_backpressure_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (rx_level == LVL_W'(DEPTH)) |-> !rx_ready);
endmodule

// File: tb/aud_fifo_ctl_bench.sv
module aud_fifo_ctl_bench;
  import aud_fifo_pkg::*;
  localparam int D  = 8;
  localparam int FC = 3;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  always #5 clk = ~clk;

  logic        reg_wr = 0, reg_rd = 0, tx_ready = 0, rx_valid = 0;
  logic [2:0]  reg_addr = 0;
  logic [31:0] reg_wdata = 0, rx_data = 0;
  logic [31:0] reg_rdata, tx_data;
  logic        tx_valid, rx_ready, irq, tx_dma_req, rx_dma_req;

  aud_fifo_ctl #(.DEPTH(D), .FLUSH_CYCLES(FC)) u_aud_fifo_ctl (
    .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_rd(reg_rd),
    .reg_addr(reg_addr), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
    .tx_valid(tx_valid), .tx_ready(tx_ready), .tx_data(tx_data),
    .rx_valid(rx_valid), .rx_ready(rx_ready), .rx_data(rx_data),
    .irq(irq), .tx_dma_req(tx_dma_req), .rx_dma_req(rx_dma_req));

  int errs = 0, checks = 0;
  bit done = 0;

  // behavioural reference
  logic [31:0] txq[$], rxq[$];
  logic [31:0] m_ictl = 0, m_dctl = 0, m_rdata = 0;
  bit m_und = 0, m_txb = 0, m_rxb = 0;
  int m_txc = 0, m_rxc = 0;
  string m_rtag = "R12 rdata";

  localparam logic [31:0] ICTL_MASK = 32'h1 | (32'h1 << 16) | ((D-1) << 4) | ((D-1) << 20);
  localparam logic [31:0] DCTL_MASK = (32'h1 << 24) | ((D-1) << 16) | (32'h1 << 8) | (D-1);

  function automatic bit f_txv(); return txq.size() > 0 && !m_txb; endfunction
  function automatic bit f_rxr(); return rxq.size() < D && !m_rxb; endfunction
  function automatic bit f_txe(); return txq.size() <= int'((m_ictl >> 4) & (D-1)) + 1; endfunction
  function automatic bit f_rxf(); return rxq.size() >= int'((m_ictl >> 20) & (D-1)) + 1; endfunction
  function automatic bit f_irq(); return (f_txe() && m_ictl[0]) || (f_rxf() && m_ictl[16]); endfunction
  function automatic bit f_txd(); return m_dctl[8] && txq.size() <= int'(m_dctl & (D-1)); endfunction
  function automatic bit f_rxd(); return m_dctl[24] && rxq.size() > int'((m_dctl >> 16) & (D-1)); endfunction

  task automatic chk(string tag, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errs++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic compare();
    chk("R4 tx_valid", {31'b0, tx_valid}, {31'b0, f_txv()});
    if (f_txv()) chk("R4 tx_data", tx_data, txq[0]);
    chk("R5 rx_ready", {31'b0, rx_ready}, {31'b0, f_rxr()});
    chk("R9 irq", {31'b0, irq}, {31'b0, f_irq()});
    chk("R10 tx_dma_req", {31'b0, tx_dma_req}, {31'b0, f_txd()});
    chk("R10 rx_dma_req", {31'b0, rx_dma_req}, {31'b0, f_rxd()});
    chk(m_rtag, reg_rdata, m_rdata);
  endtask

  task automatic model_step();
    logic [31:0] rv;
    int sz_tx, sz_rx;
    bit txv, rxr;
    rv = 0; sz_tx = txq.size(); sz_rx = rxq.size(); txv = f_txv(); rxr = f_rxr();
    if (reg_rd) begin
      case (reg_addr)
        3'd0: begin rv = m_ictl; m_rtag = "R12 ictl"; end
        3'd1: begin rv = {15'b0, f_rxf(), 14'b0, m_und, f_txe()}; m_rtag = "R6 status"; end
        3'd2: begin rv = m_dctl; m_rtag = "R12 dctl"; end
        3'd3: begin rv = {30'b0, m_rxb, m_txb}; m_rtag = "R11 flush"; end
        3'd4: begin rv = 0; m_rtag = "R12 txdata"; end
        3'd5: begin
          m_rtag = "R3 rxdata";
          if (sz_rx > 0 && !m_rxb) rv = rxq.pop_front();
        end
        3'd6: begin rv = sz_tx; m_rtag = "R1 txlvl"; end
        default: begin rv = sz_rx; m_rtag = "R1 rxlvl"; end
      endcase
      m_rdata = rv;
    end
    if (txv && tx_ready) void'(txq.pop_front());
    if (reg_wr && reg_addr == 3'd4 && !m_txb && sz_tx < D) txq.push_back(reg_wdata);
    if (rx_valid && rxr) rxq.push_back(rx_data);
    if (tx_ready && !txv) m_und = 1;
    else if (reg_wr && reg_addr == 3'd0 && reg_wdata[2]) m_und = 0;
    if (reg_wr && reg_addr == 3'd0) m_ictl = reg_wdata & ICTL_MASK;
    if (reg_wr && reg_addr == 3'd2) m_dctl = reg_wdata & DCTL_MASK;
    if (m_txb) begin
      if (m_txc == 0) begin m_txb = 0; txq.delete(); end else m_txc--;
    end else if (reg_wr && reg_addr == 3'd3 && reg_wdata[0]) begin m_txb = 1; m_txc = FC - 1; end
    if (m_rxb) begin
      if (m_rxc == 0) begin m_rxb = 0; rxq.delete(); end else m_rxc--;
    end else if (reg_wr && reg_addr == 3'd3 && reg_wdata[1]) begin m_rxb = 1; m_rxc = FC - 1; end
  endtask

  task automatic cyc();
    model_step();
    @(negedge clk);
    compare();
  endtask

  task automatic wr(logic [2:0] a, logic [31:0] d);
    reg_wr = 1; reg_addr = a; reg_wdata = d; cyc(); reg_wr = 0;
  endtask

  task automatic rd(logic [2:0] a);
    reg_rd = 1; reg_addr = a; cyc(); reg_rd = 0;
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1;
    compare();                                   // reset state
    rd(3'd6); chk("R1 reset level", reg_rdata, 0);
    rd(3'd1); chk("R6 reset status", reg_rdata, 32'h1);

    for (int i = 0; i < 3; i++) wr(3'd4, 32'hA0 + i);
    rd(3'd6); chk("R1 level 3", reg_rdata, 3);
    rd(3'd1); chk("R6 above threshold", reg_rdata, 0);
    wr(3'd0, (3 << 4) | 1);
    rd(3'd1); chk("R6 at threshold 4", reg_rdata, 32'h1);
    chk("R9 irq on", {31'b0, irq}, 1);

    for (int i = 0; i < 7; i++) wr(3'd4, 32'hB0 + i);
    rd(3'd6); chk("R2 dropped when full", reg_rdata, D);
    chk("R9 irq off", {31'b0, irq}, 0);

    for (int i = 0; i < 20; i++) begin tx_ready = ~tx_ready; cyc(); end
    tx_ready = 0;
    rd(3'd1); chk("R8 underrun set", reg_rdata, 32'h3);
    wr(3'd0, (3 << 4) | 1 | 4);
    rd(3'd1); chk("R8 underrun cleared", reg_rdata, 32'h1);
    rd(3'd0); chk("R8 clear bit reads 0", reg_rdata, (3 << 4) | 1);

    rd(3'd5); chk("R3 empty pop", reg_rdata, 0);
    rd(3'd7); chk("R3 level stays", reg_rdata, 0);

    rx_valid = 1;
    for (int i = 0; i < 10; i++) begin rx_data = 32'h100 + i; cyc(); end
    rx_valid = 0;
    rd(3'd7); chk("R2 rx capped", reg_rdata, D);
    chk("R5 rx_ready low when full", {31'b0, rx_ready}, 0);
    wr(3'd0, (4 << 20) | (1 << 16));
    rd(3'd1); chk("R7 rx full", reg_rdata, 32'h10001);
    chk("R9 irq rx", {31'b0, irq}, 1);
    for (int i = 0; i < 4; i++) begin
      rd(3'd5); chk("R1 rx order", reg_rdata, 32'h100 + i);
    end
    rd(3'd1); chk("R7 rx below", reg_rdata, 32'h1);

    wr(3'd2, (1 << 24) | (3 << 16) | (1 << 8) | 2);
    chk("R10 rx req", {31'b0, rx_dma_req}, 1);
    chk("R10 tx req", {31'b0, tx_dma_req}, 1);
    rd(3'd5);
    chk("R10 rx req drop", {31'b0, rx_dma_req}, 0);

    for (int i = 0; i < 3; i++) wr(3'd4, 32'hC0 + i);
    wr(3'd3, 1);
    rd(3'd3); chk("R11 busy 1", reg_rdata, 1);
    chk("R11 frozen valid", {31'b0, tx_valid}, 0);
    rd(3'd6); chk("R11 frozen level", reg_rdata, 3);
    rd(3'd3); chk("R11 busy 3", reg_rdata, 1);
    rd(3'd3); chk("R11 busy done", reg_rdata, 0);
    rd(3'd6); chk("R11 emptied", reg_rdata, 0);
    wr(3'd3, 2);
    repeat (4) cyc();
    rd(3'd7); chk("R11 rx emptied", reg_rdata, 0);

    for (int n = 0; n < 600; n++) begin
      logic [31:0] r;
      r = $urandom;
      tx_ready = r[0];
      rx_valid = r[1];
      rx_data  = $urandom;
      reg_wr = 0; reg_rd = 0;
      reg_addr = r[6:4];
      reg_wdata = $urandom;
      if (r[9:7] == 0 && reg_addr == 3'd3) reg_wdata[1:0] = 0;
      if (r[3:2] == 2'd1) reg_wr = 1;
      else if (r[3:2] == 2'd2) reg_rd = 1;
      cyc();
    end
    reg_wr = 0; reg_rd = 0; tx_ready = 0; rx_valid = 0;
    cyc();
    done = 1;
    $display("Result: errors=%0d of %0d checks", errs, checks);
    $finish;
  end

  initial begin
    #(200000 * 10);
    if (!done) begin
      checks++; errs++;
      $display("FAIL watchdog expired actual=hung expected=finished");
      $display("Result: errors=%0d of %0d checks", errs, checks);
      $finish;
    end
  end
endmodule